// File: doc/BRIEF.md
# Compare and Test Flag Unit

This block evaluates the condition flags of a 32-bit datapath without producing a data result. It keeps a processor status word and, on a strobed command, replaces some of its flag bits with the outcome of a compare or a test. A compare subtracts an operand from the second register and records zero, sign, borrow and signed overflow. A test ANDs two registers and records zero and sign. Two further commands set or clear an interrupt-disable bit.

The surrounding pipeline presents the register values, the immediate field and a 3-bit command code together with a one-cycle valid strobe. The status word is held in a register and driven continuously on an output port, so later stages can read the flags in the cycle after the command. Register storage and instruction decode are left to neighbouring blocks.

Top module: `flag_eval_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the status word reads all zeros until a command changes it.
- R2: Command code 1 (register compare) forms src_b minus src_a. Bit 0 (Z) is set when the 32-bit difference is zero, and bit 1 (S) copies bit 31 of the difference. No data result is produced.
- R3: Command code 2 (immediate compare) sign-extends the 5-bit imm field to 32 bits and uses it in place of src_a. The flags follow the same rules as R2, R4 and R5.
- R4: On either compare, bit 3 (CY) is set exactly when src_b is unsigned-less-than the subtracted operand.
- R5: On either compare, bit 2 (OV) is set when the two operands differ in bit 31 and the difference differs from src_b in bit 31.
- R6: Command code 3 (test) sets Z when src_a AND src_b is zero and copies bit 31 of that AND into S. It clears OV and leaves CY unchanged.
- R7: Command code 4 sets bit 5 (ID) and command code 5 clears it. Neither changes any other bit.
- R8: A command takes effect at the rising clock edge where op_valid is high. With op_valid low, or with code 0, 6 or 7, the status word keeps its value.
- R9: Bit 4 (SAT) and bits 31 to 6 always read zero. Compares and tests change none of bits 4 to 31, and only di and ei change bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | One-cycle command strobe |
| op_code | input | 3 | Command: 0 none, 1 cmp reg, 2 cmp imm, 3 tst, 4 di, 5 ei |
| src_a | input | 32 | First register operand (subtrahend of a register compare) |
| src_b | input | 32 | Second register operand (minuend of a compare) |
| imm | input | 5 | Signed immediate for the immediate compare |
| psw_o | output | 32 | Status word: Z bit 0, S bit 1, OV bit 2, CY bit 3, SAT bit 4, ID bit 5 |

## Verification
Each command is registered once, so its flags appear on psw_o at the first rising edge that samples the strobe. They hold until the next accepted command. The bench drives a command at a falling edge, advances the reference model at the rising edge that follows, and compares the whole status word at the next falling edge, on every cycle. After reset is released, the two-stage reset synchronizer holds the register in reset for two more edges. The bench therefore waits three falling edges before its first command and checks that the word stays zero throughout.

// File: rtl/flag_pkg.sv
package flag_pkg;

  localparam int PSW_W  = 32;
  localparam int BIT_Z   = 0;
  localparam int BIT_S   = 1;
  localparam int BIT_OV  = 2;
  localparam int BIT_CY  = 3;
  localparam int BIT_SAT = 4;
  localparam int BIT_ID  = 5;
  localparam int LIVE_W  = BIT_ID + 1;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_CMP_R = 3'd1,
    OP_CMP_I = 3'd2,
    OP_TST   = 3'd3,
    OP_DI    = 3'd4,
    OP_EI    = 3'd5
  } op_e;

  typedef struct packed {
    logic z;
    logic s;
    logic ov;
    logic cy;
  } flags_t;

endpackage

// File: rtl/flag_rst_sync.sv
module flag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], 1'b1};
  end

  assign rst_q = chain[LAST];
endmodule

// File: rtl/flag_cmp_path.sv
module flag_cmp_path
  import flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] reg_sub,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output flags_t            flags
);
  localparam int EXT_W = DATA_W - IMM_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] subtrahend;
  logic [DATA_W:0]   wide_diff;
  logic [DATA_W-1:0] diff;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    subtrahend = use_imm ? imm_ext : reg_sub;
    wide_diff  = {1'b0, minuend} - {1'b0, subtrahend};
    diff       = wide_diff[DATA_W-1:0];
    flags.z    = (diff == '0);
    flags.s    = diff[MSB];
    flags.cy   = wide_diff[DATA_W];
    flags.ov   = (minuend[MSB] ^ subtrahend[MSB]) & (diff[MSB] ^ minuend[MSB]);
  end
endmodule

// File: rtl/flag_tst_path.sv
module flag_tst_path #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              z,
  output logic              s
);
  logic [DATA_W-1:0] masked;

  always_comb begin
    masked = opa & opb;
    z      = (masked == '0);
    s      = masked[DATA_W-1];
  end
endmodule

// File: rtl/flag_psw_reg.sv
module flag_psw_reg
  import flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_q,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  flags_t           cmp_flags,
  input  logic             tst_z,
  input  logic             tst_s,
  output logic [PSW_W-1:0] psw
);
  logic [LIVE_W-1:0] live_q;
  logic [LIVE_W-1:0] live_d;
  logic              load;

  always_comb begin
    live_d = live_q;
    load   = 1'b0;
    if (op_valid) begin
      unique case (op_code)
        OP_CMP_R, OP_CMP_I: begin
          load           = 1'b1;
          live_d[BIT_Z]  = cmp_flags.z;
          live_d[BIT_S]  = cmp_flags.s;
          live_d[BIT_OV] = cmp_flags.ov;
          live_d[BIT_CY] = cmp_flags.cy;
        end
        OP_TST: begin
          load           = 1'b1;
          live_d[BIT_Z]  = tst_z;
          live_d[BIT_S]  = tst_s;
          live_d[BIT_OV] = 1'b0;
        end
        OP_DI: begin
          load           = 1'b1;
          live_d[BIT_ID] = 1'b1;
        end
        OP_EI: begin
          load           = 1'b1;
          live_d[BIT_ID] = 1'b0;
        end
        default: load = 1'b0;
      endcase
    end
    live_d[BIT_SAT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)    live_q <= '0;
    else if (load) live_q <= live_d;
  end

  assign psw = {{(PSW_W-LIVE_W){1'b0}}, live_q};
endmodule

// File: rtl/flag_eval_unit.sv
module flag_eval_unit
  import flag_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 5,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [PSW_W-1:0]  psw_o
);
  logic   rst_q;
  flags_t cmp_flags;
  logic   tst_z;
  logic   tst_s;
  logic   use_imm;

  assign use_imm = (op_code == OP_CMP_I);

  flag_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  flag_cmp_path #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cmp (
    .minuend (src_b),
    .reg_sub (src_a),
    .imm     (imm),
    .use_imm (use_imm),
    .flags   (cmp_flags)
  );

  flag_tst_path #(.DATA_W(DATA_W)) u_tst (
    .opa (src_a),
    .opb (src_b),
    .z   (tst_z),
    .s   (tst_s)
  );

  flag_psw_reg u_psw (
    .clk       (clk),
    .rst_q     (rst_q),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .cmp_flags (cmp_flags),
    .tst_z     (tst_z),
    .tst_s     (tst_s),
    .psw       (psw_o)
  );
endmodule

// File: rtl/flag_eval_unit_chk.sv
module flag_eval_unit_chk
  import flag_pkg::*;
(
  input logic              clk,
  input logic              rst_q,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [31:0]       src_a,
  input logic [31:0]       src_b,
  input logic [PSW_W-1:0]  psw_o
);
  p_cmp_zero_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_CMP_R) |=> (psw_o[BIT_Z] == ($past(src_a) == $past(src_b))));

  p_cmp_borrow_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_CMP_R) |=> (psw_o[BIT_CY] == ($past(src_b) < $past(src_a))));

  p_tst_ov_clear_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_TST) |=> !psw_o[BIT_OV]);

  p_tst_cy_keep_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_TST) |=> $stable(psw_o[BIT_CY]));

  p_di_sets_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_DI) |=> (psw_o[BIT_ID] && $stable(psw_o[BIT_CY:BIT_Z])));

  p_ei_clears_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_EI) |=> (!psw_o[BIT_ID] && $stable(psw_o[BIT_CY:BIT_Z])));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (!op_valid || op_code == OP_NONE || op_code > OP_EI) |=> $stable(psw_o));

  p_flags_keep_id_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code != OP_DI && op_code != OP_EI) |=> $stable(psw_o[BIT_ID]));

  p_dead_bits_r9: assert property (@(posedge clk)
    (psw_o[PSW_W-1:BIT_SAT+1] == '0 || psw_o[PSW_W-1:BIT_ID+1] == '0) && !psw_o[BIT_SAT]);

  p_reset_zero_r1: assert property (@(posedge clk) !rst_q |-> (psw_o == '0));
endmodule

bind flag_eval_unit flag_eval_unit_chk u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .op_valid (op_valid),
  .op_code  (op_code),
  .src_a    (src_a),
  .src_b    (src_b),
  .psw_o    (psw_o)
);

// File: tb/flag_eval_unit_tb.sv
`timescale 1ns/1ps
module flag_eval_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [4:0]  imm;
  logic [31:0] psw_o;

  int          checks = 0;
  int          errors = 0;
  logic [31:0] model_psw;

  always #2.5 clk = ~clk;

  flag_eval_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .imm(imm), .psw_o(psw_o)
  );

  function automatic logic [31:0] next_word(logic [31:0] cur, logic v, logic [2:0] op,
                                            logic [31:0] a, logic [31:0] b, logic [4:0] im);
    logic [31:0] n;
    logic [31:0] sub;
    logic [31:0] r;
    logic signed [4:0] sim;
    n = cur;
    if (!v) return n;
    case (op)
      3'd1, 3'd2: begin
        sim = im;
        sub = (op == 3'd2) ? 32'(sim) : a;
        r = b - sub;
        n[0] = (r == 0);
        n[1] = r[31];
        n[2] = (b[31] != sub[31]) && (r[31] != b[31]);
        n[3] = (b < sub);
      end
      3'd3: begin
        r = a & b;
        n[0] = (r == 0);
        n[1] = r[31];
        n[2] = 1'b0;
      end
      3'd4: n[5] = 1'b1;
      3'd5: n[5] = 1'b0;
      default: ;
    endcase
    return n;
  endfunction

  function automatic string req_of(logic v, logic [2:0] op);
    if (!v) return "R8";
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s psw got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, update the model at the rising edge, compare at the next falling edge.
  task automatic step(logic v, logic [2:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] im,
                      string tag = "");
    op_valid = v; op_code = op; src_a = a; src_b = b; imm = im;
    @(posedge clk);
    model_psw = next_word(model_psw, v, op, a, b, im);
    @(negedge clk);
    check(tag == "" ? req_of(v, op) : tag, psw_o, model_psw);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_psw = '0;
    op_valid = 1'b0; op_code = 3'd0; src_a = '0; src_b = '0; imm = '0;
    #1;
    check("R1", psw_o, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset synchronizer: register leaves reset after two rising edges.
    repeat (3) begin
      @(negedge clk);
      check("R1", psw_o, 32'h0);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog psw got %h expected completion", psw_o);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R2: equal operands give Z, difference sign into S
    step(1, 3'd1, 32'h1234_5678, 32'h1234_5678, 5'd0, "R2");
    check("R2", psw_o, 32'h1);
    step(1, 3'd1, 32'h0000_0001, 32'h0000_0000, 5'd0, "R4");
    check("R4", psw_o, 32'h0000_000A);
    step(1, 3'd1, 32'h0000_0001, 32'h8000_0000, 5'd0, "R5");
    check("R5", psw_o, 32'h0000_0004);
    step(1, 3'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 5'd0, "R5");
    check("R5", psw_o, 32'h0000_000E);
    // R3: imm 5'b10000 sign-extends to 0xFFFFFFF0
    step(1, 3'd2, 32'hDEAD_BEEF, 32'hFFFF_FFF0, 5'b10000, "R3");
    check("R3", psw_o, 32'h1);
    step(1, 3'd2, 32'h0, 32'h0000_000F, 5'd15, "R3");
    check("R3", psw_o, 32'h1);
    step(1, 3'd2, 32'h0, 32'h0000_0000, 5'b11111, "R3");
    // R6: tst keeps CY, clears OV
    step(1, 3'd1, 32'h0000_0001, 32'h8000_0000, 5'd0, "R5");
    step(1, 3'd1, 32'h0000_0005, 32'h0000_0002, 5'd0, "R4");
    step(1, 3'd3, 32'hF0F0_0000, 32'h0F0F_0000, 5'd0, "R6");
    check("R6", psw_o, 32'h0000_0009);
    step(1, 3'd3, 32'h8000_0001, 32'hC000_0000, 5'd0, "R6");
    check("R6", psw_o, 32'h0000_000A);
    // R7: di / ei
    step(1, 3'd4, 32'h0, 32'h0, 5'd0, "R7");
    check("R7", psw_o, 32'h0000_002A);
    step(1, 3'd1, 32'h0, 32'h0, 5'd0, "R9");
    check("R9", psw_o, 32'h0000_0021);
    step(1, 3'd5, 32'h0, 32'h0, 5'd0, "R7");
    check("R7", psw_o, 32'h0000_0001);
    // R8: idle and reserved codes
    step(1, 3'd4, 32'h0, 32'h0, 5'd0);
    step(0, 3'd5, 32'h0, 32'h0, 5'd0, "R8");
    step(0, 3'd1, 32'h1, 32'h0, 5'd0, "R8");
    step(1, 3'd6, 32'h1, 32'h0, 5'd0, "R8");
    step(1, 3'd7, 32'h1, 32'h0, 5'd0, "R8");
    step(1, 3'd0, 32'h1, 32'h0, 5'd0, "R8");
    check("R8", psw_o, 32'h0000_0021);

    // Mixed stimulus, compared every clock
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = (i % 5 == 0) ? a : $urandom();
      if (i % 7 == 0) b = {b[31], 31'h0};
      step(($urandom() % 8) != 0, 3'($urandom()), a, b, 5'($urandom()));
      if (psw_o[31:6] != 0 || psw_o[4]) begin
        check("R9", psw_o & 32'h0000_002F, psw_o);
      end
    end

    // R1: reset in mid-run clears the word
    step(1, 3'd4, 32'h0, 32'h0, 5'd0);
    step(1, 3'd1, 32'h0, 32'h1, 5'd0);
    do_reset();
    step(1, 3'd2, 32'h0, 32'h0000_0003, 5'd3, "R3");
    check("R3", psw_o, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule